// File: doc/BRIEF.md
# LIFO Register Stack with Shared Data Bus

This block is a small last-in-first-out store built from flip-flops. It holds eight 8-bit words. One internal level counter tracks how many words are held. The same counter also gives the slot the next push writes and the slot the next pop reads. Words come in and go out over one bidirectional bus. The stack drives that bus only while a pop is requested. At all other times the bus is left floating, so the surrounding logic can put write data on it.

A push samples the bus and stores the word on top of the stack. A pop removes the top word and loads it into an output register. That register is visible at all times on a separate read port and is placed on the bus while pop is high. Three registered flags report the state: full, empty, and a sticky error. The error flag records any push into a full stack and any pop from an empty one. When both strobes are high in the same cycle, the push is performed.

The reset is asynchronous and active low. It clears the level counter, the flags, the output register and every storage word.

Top module: `lifo_stack`

## Requirements
- R1: While rst_n is low, empty_o reads 1, full_o reads 0, err_o reads 0 and rd_data_o reads 0.
- R2: A push into a stack that is not full stores the bus value as the new top word. Empty_o reads 0 after that clock edge.
- R3: A pop (with push low) from a stack that is not empty loads the most recently stored remaining word into rd_data_o at that clock edge. Successive pops return words in the reverse of their push order. Without a successful pop, rd_data_o holds its value.
- R4: full_o reads 1 after the edge at which the eighth word is stored. A push while full sets err_o and leaves all stored words and the level unchanged.
- R5: A pop with push low while empty sets err_o, leaves rd_data_o unchanged and keeps empty_o at 1.
- R6: Once set, err_o stays 1 until the next reset, whatever the strobes do.
- R7: A successful pop from a full stack clears full_o at that edge.
- R8: With push and pop both high, only the push is performed, provided the stack is not full. The value stored is the one on the bus, which at that time is rd_data_o driven by the stack.
- R9: While pop_i is 1, data_io carries rd_data_o. While pop_i is 0, the stack leaves data_io at high impedance.
- R10: Lowering rst_n clears the flags and rd_data_o at once, without waiting for a clock edge, even in the middle of operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_i | input | 1 | Store the bus word on top of the stack |
| pop_i | input | 1 | Remove the top word into the read register and drive the bus |
| data_io | inout | 8 | Shared data bus: write data in, read register out during pop |
| rd_data_o | output | 8 | Read register (split view of the outgoing data) |
| full_o | output | 1 | Eight words held |
| empty_o | output | 1 | No words held |
| err_o | output | 1 | Sticky: overflow or underflow attempted |

## Verification
The bench builds the block with its default parameters: a depth of eight and a width of eight. With these values both boundaries are reached in a handful of cycles. Eight pushes reach the full boundary and a ninth attempts overflow. Underflow is one pop away from reset. A mixed push/pop walk also crosses both flags several times. Eight-bit words let the bench tell each stored word apart by value, so any wrong ordering or lost word shows up as a data mismatch.

// File: rtl/lifo_pkg.sv
package lifo_pkg;

  typedef enum logic [2:0] {
    OP_IDLE,
    OP_PUSH,
    OP_POP,
    OP_OVERFLOW,
    OP_UNDERFLOW
  } lifo_op_e;

  // Push wins over pop; a refused operation is reported as an error kind.
  function automatic lifo_op_e decode_op(input logic push, input logic pop,
                                         input logic full, input logic empty);
    if (push) return full ? OP_OVERFLOW : OP_PUSH;
    if (pop)  return empty ? OP_UNDERFLOW : OP_POP;
    return OP_IDLE;
  endfunction

  // Level after an operation; refused operations keep the level.
  function automatic int unsigned next_level(input int unsigned level,
                                             input lifo_op_e op);
    case (op)
      OP_PUSH: return level + 1;
      OP_POP:  return level - 1;
      default: return level;
    endcase
  endfunction

endpackage

// File: rtl/lifo_ctrl.sv
module lifo_ctrl
  import lifo_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int CNT_W = $clog2(DEPTH + 1),
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  logic             pop_i,
  output logic             wr_en_o,
  output logic [IDX_W-1:0] wr_idx_o,
  output logic             rd_en_o,
  output logic [IDX_W-1:0] rd_idx_o,
  output logic             full_o,
  output logic             empty_o,
  output logic             err_o
);

  logic [CNT_W-1:0] level_q, level_d;
  logic             full_q, empty_q, err_q;
  lifo_op_e         op;

  // Named events for the checks below.
  logic ev_push, ev_pop, ev_overflow, ev_underflow;

  assign op           = decode_op(push_i, pop_i, full_q, empty_q);
  assign ev_push      = (op == OP_PUSH);
  assign ev_pop       = (op == OP_POP);
  assign ev_overflow  = (op == OP_OVERFLOW);
  assign ev_underflow = (op == OP_UNDERFLOW);

  assign level_d  = CNT_W'(next_level(32'(level_q), op));
  assign wr_idx_o = level_q[IDX_W-1:0];
  assign rd_idx_o = IDX_W'(level_q - 1'b1);
  assign wr_en_o  = ev_push;
  assign rd_en_o  = ev_pop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= '0;
      full_q  <= 1'b0;
      empty_q <= 1'b1;
      err_q   <= 1'b0;
    end else begin
      level_q <= level_d;
      full_q  <= (level_d == CNT_W'(DEPTH));
      empty_q <= (level_d == '0);
      err_q   <= err_q | ev_overflow | ev_underflow;
    end
  end

  assign full_o  = full_q;
  assign empty_o = empty_q;
  assign err_o   = err_q;

  p_overflow_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_overflow |=> $stable(level_q) && err_q && full_q);

  p_underflow_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_underflow |=> $stable(level_q) && err_q && empty_q);

  p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);

  p_full_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    full_q && pop_i && !push_i |=> !full_q);

  p_push_priority_r8: assert property (@(posedge clk) disable iff (!rst_n)
    push_i && pop_i && !full_q |=> level_q == $past(level_q) + 1'b1);

  p_flags_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(full_q && empty_q));

endmodule

// File: rtl/lifo_store.sv
module lifo_store #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 8,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [WIDTH-1:0] wr_data_i,
  input  logic             rd_en_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [WIDTH-1:0] rd_data_o
);

  logic [WIDTH-1:0] slot_q [DEPTH];
  logic [WIDTH-1:0] out_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) slot_q[g] <= '0;
      else if (wr_en_i && (wr_idx_i == IDX_W'(g))) slot_q[g] <= wr_data_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       out_q <= '0;
    else if (rd_en_i) out_q <= slot_q[rd_idx_i];
  end

  assign rd_data_o = out_q;

  p_read_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en_i |=> $stable(rd_data_o));

  p_single_access_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en_i && rd_en_i));

endmodule

// File: rtl/lifo_bus.sv
module lifo_bus #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             drive_i,
  input  logic [WIDTH-1:0] out_data_i,
  inout  wire  [WIDTH-1:0] bus_io,
  output logic [WIDTH-1:0] in_data_o
);

  assign bus_io    = drive_i ? out_data_i : {WIDTH{1'bz}};
  assign in_data_o = bus_io;

  p_bus_drive_r9: assert property (@(posedge clk) disable iff (!rst_n)
    drive_i |-> bus_io == out_data_i);

endmodule

// File: rtl/lifo_stack.sv
module lifo_stack #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  logic             pop_i,
  inout  wire  [WIDTH-1:0] data_io,
  output logic [WIDTH-1:0] rd_data_o,
  output logic             full_o,
  output logic             empty_o,
  output logic             err_o
);

  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic             wr_en, rd_en;
  logic [IDX_W-1:0] wr_idx, rd_idx;
  logic [WIDTH-1:0] bus_in, out_word;

  lifo_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .push_i(push_i), .pop_i(pop_i),
    .wr_en_o(wr_en), .wr_idx_o(wr_idx), .rd_en_o(rd_en), .rd_idx_o(rd_idx),
    .full_o(full_o), .empty_o(empty_o), .err_o(err_o)
  );

  lifo_store #(.DEPTH(DEPTH), .WIDTH(WIDTH), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_idx_i(wr_idx),
    .wr_data_i(bus_in), .rd_en_i(rd_en), .rd_idx_i(rd_idx),
    .rd_data_o(out_word)
  );

  lifo_bus #(.WIDTH(WIDTH)) u_bus (
    .clk(clk), .rst_n(rst_n), .drive_i(pop_i), .out_data_i(out_word),
    .bus_io(data_io), .in_data_o(bus_in)
  );

  assign rd_data_o = out_word;

endmodule

// File: tb/sim_lifo_stack.sv
`timescale 1ns/1ps
module sim_lifo_stack;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       push = 1'b0, pop = 1'b0;
  logic [7:0] drv = 8'h00;
  logic       drv_en = 1'b0;
  wire  [7:0] data_io;
  logic [7:0] rd_data;
  logic       full, empty, err;

  assign data_io = drv_en ? drv : 8'bz;

  always #2 clk = ~clk;

  lifo_stack u0 (
    .clk(clk), .rst_n(rst_n), .push_i(push), .pop_i(pop), .data_io(data_io),
    .rd_data_o(rd_data), .full_o(full), .empty_o(empty), .err_o(err)
  );

  int vectors = 0, miscompares = 0;
  logic [7:0] mq[$];
  logic [7:0] m_dout = 8'h00;
  logic       m_err = 1'b0;

  task automatic check(string req, string what, logic [7:0] got, logic [7:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, got, exp);
    end
  endtask

  task automatic compare_all(string req);
    check(req, "full",  8'(full),  8'(mq.size() == 8));
    check(req, "empty", 8'(empty), 8'(mq.size() == 0));
    check(req, "err",   8'(err),   8'(m_err));
    check(req, "rd_data", rd_data, m_dout);
  endtask

  task automatic step(bit ps, bit pp, logic [7:0] d, string req);
    @(negedge clk);
    push = ps; pop = pp; drv = d; drv_en = ps && !pp;
    #1;
    if (pp)       check({req, " R9"}, "bus driven", data_io, m_dout);
    else if (!ps) check({req, " R9"}, "bus released", data_io, 8'bz);
    @(posedge clk);
    if (ps) begin
      if (mq.size() == 8) m_err = 1'b1;
      else mq.push_back(pp ? m_dout : d);
    end else if (pp) begin
      if (mq.size() == 0) m_err = 1'b1;
      else m_dout = mq.pop_back();
    end
    #1;
    compare_all(req);
  endtask

  task automatic do_reset(string req);
    @(negedge clk);
    #1;
    rst_n = 1'b0; push = 1'b0; pop = 1'b0; drv_en = 1'b0;
    mq.delete(); m_dout = 8'h00; m_err = 1'b0;
    #0.5;
    compare_all(req);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(4.0 * 200000);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #3;
    compare_all("R1");
    @(negedge clk);
    rst_n = 1'b1;
    step(0, 0, 8'h00, "R9");
    // R2 and R3: LIFO ordering
    step(1, 0, 8'h11, "R2");
    step(1, 0, 8'h22, "R2");
    step(1, 0, 8'h33, "R2");
    step(0, 1, 8'h00, "R3");
    step(0, 0, 8'h00, "R3");
    step(0, 1, 8'h00, "R3");
    step(0, 1, 8'h00, "R3");
    // R5 underflow, R6 sticky
    step(0, 1, 8'h00, "R5");
    step(0, 0, 8'h00, "R6");
    step(1, 0, 8'h44, "R6");
    step(0, 1, 8'h00, "R6");
    do_reset("R10");
    // R4 fill, overflow, then drain (R7)
    for (int i = 0; i < 8; i++) step(1, 0, 8'(8'hA0 + i), "R4");
    step(1, 0, 8'hEE, "R4");
    step(0, 1, 8'h00, "R7");
    for (int i = 0; i < 7; i++) step(0, 1, 8'h00, "R4");
    do_reset("R1");
    // R8 simultaneous push and pop
    step(1, 0, 8'h5A, "R8");
    step(0, 1, 8'h00, "R8");
    step(1, 0, 8'h6B, "R8");
    step(1, 1, 8'h00, "R8");
    step(0, 1, 8'h00, "R8");
    step(0, 1, 8'h00, "R8");
    // Mixed walk
    for (int i = 0; i < 60; i++) begin
      bit ps = ((i * 7) % 5) < 3;
      bit pp = ((i * 3) % 4) == 1;
      step(ps, pp, 8'(i * 37 + 5), "R3");
    end
    do_reset("R10");
    step(0, 0, 8'h00, "R1");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule